// File: doc/BRIEF.md
# Internal Oscillator Frequency Postscaler

This block turns two internal clocks into the selectable internal-oscillator output. One input is a fast clock of nominally 16 MHz. It drives a free-running binary counter, and each counter bit gives a divided tap. The other input is a slow clock of nominally 31 kHz. A 3-bit frequency code picks the undivided fast clock, one of six divided taps, or a low-frequency path. On the low-frequency path, a source bit chooses between the slow clock and the fast clock divided by 512.

Software loads the code and the source bit together through a single write strobe. The new setting reaches the output one fast-clock edge after the write. After a reset the code returns to the 1 MHz setting. The slow clock is also passed unchanged to a separate output for the watchdog and the clock monitor, whatever the settings are.

Top module: `osc_postscaler`

## Requirements
- R1: While reset is low, the frequency code is set to 3'b011 (1 MHz) and the source bit to 0. The divider counter is held at zero, so `clk_out` stays low. After reset is released, the output period is 16 fast-clock periods.
- R2: For codes 3'b111, 3'b110, 3'b101, 3'b100, 3'b011, 3'b010 and 3'b001, the `clk_out` period is 1, 2, 4, 8, 16, 32 and 64 fast-clock periods respectively.
- R3: With code 3'b000 and the source bit at 1, the `clk_out` period is 512 fast-clock periods.
- R4: With code 3'b000 and the source bit at 0, `clk_out` follows `slow_clk` and has its period.
- R5: When the code is not 3'b000, the source bit has no effect on the `clk_out` period.
- R6: `lf_clk_out` always equals `slow_clk`, whatever the code and source bit are.
- R7: A write with `cfg_we` high is captured at the next rising edge of `fast_clk`. From that edge on, `clk_out` runs at the new setting, with no restart of the divider.
- R8: If `cfg_we` is high in the same cycle as an active reset, the reset wins and the code becomes 3'b011.
- R9: Every divided output, including the divide-by-512 path, has a high time equal to half its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast internal clock, nominally 16 MHz; clocks the divider and the settings |
| slow_clk | input | 1 | Slow internal clock, nominally 31 kHz |
| rst_n | input | 1 | Synchronous active-low reset, sampled on `fast_clk` |
| cfg_we | input | 1 | Write strobe for the code and the source bit |
| cfg_freq | input | 3 | Frequency code to load (encoding as in R1 to R4) |
| cfg_src | input | 1 | Source bit to load: 1 selects fast/512, 0 selects `slow_clk` |
| clk_out | output | 1 | Selected internal-oscillator clock |
| lf_clk_out | output | 1 | Slow clock for the watchdog and the clock monitor |

## Verification
A settings write and a reset can arrive in the same fast-clock cycle. The bench provokes this by holding `rst_n` low while it raises `cfg_we` with a code of 3'b110. It then judges the result by measuring the output period after reset is released: the period must be the 1 MHz default, not 8 MHz. The second collision is a write landing while the divider is in mid-count. To cover it, the bench switches from the divide-by-512 path to the fastest divided tap and samples `clk_out` on the following falling edges. The output must already alternate every cycle, with no wait for the counter to wrap.

// File: rtl/osc_pkg.sv
// Package: shared widths, frequency codes and the tap-index rule for the
// internal oscillator postscaler. Assumes a 3-bit frequency code.
package osc_pkg;

    localparam int SEL_W     = 3;
    localparam int DIV_W_DEF = 9;

    typedef enum logic [SEL_W-1:0] {
        FSEL_LOW  = 3'b000,
        FSEL_250K = 3'b001,
        FSEL_500K = 3'b010,
        FSEL_1M   = 3'b011,
        FSEL_2M   = 3'b100,
        FSEL_4M   = 3'b101,
        FSEL_8M   = 3'b110,
        FSEL_FULL = 3'b111
    } freq_code_e;

    localparam logic [SEL_W-1:0] FSEL_RESET = FSEL_1M;

    // Counter bit that carries the divided tap for a middle code:
    // code (2**SEL_W - 2) maps to bit 0 and each lower code one bit higher.
    function automatic int tap_bit(input int code);
        return (2 ** SEL_W) - 2 - code;
    endfunction

endpackage

// File: rtl/osc_div_chain.sv
// Module: free-running binary divider on the fast clock.
// Bit k of the count toggles at fast/2^(k+1). A synchronous active-low reset
// clears the count. Nothing else restarts it; in particular a settings
// write does not.
module osc_div_chain #(
    parameter int DIV_W = osc_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DIV_W-1:0] count
);

    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    // Advance the counter on every fast-clock edge, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/osc_cfg_reg.sv
// Module: holds the frequency code and the source bit.
// Both fields are loaded together on a write strobe. A synchronous
// active-low reset restores the mid-range default code and clears the
// source bit. Reset takes precedence over a write in the same cycle.
module osc_cfg_reg #(
    parameter int                        SEL_W     = osc_pkg::SEL_W,
    parameter logic [SEL_W-1:0]          RESET_SEL = osc_pkg::FSEL_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] freq_d,
    input  logic             src_d,
    output logic [SEL_W-1:0] freq_q,
    output logic             src_q
);

    // Capture a new setting on a write; restore the defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= RESET_SEL;
            src_q  <= 1'b0;
        end else if (we) begin
            freq_q <= freq_d;
            src_q  <= src_d;
        end
    end

endmodule

// File: rtl/osc_tap_mux.sv
// Module: picks the output clock for each frequency code.
// The top code passes the fast clock through undivided. The middle codes
// take counter bits. The bottom code takes either the top counter bit
// (fast/2^DIV_W) or the slow clock, depending on the source bit. The
// selection is combinational, so a new code shows as soon as it is
// registered.
// Assumes DIV_W > (2**SEL_W - 2) so that every middle tap exists.
module osc_tap_mux #(
    parameter int SEL_W = osc_pkg::SEL_W,
    parameter int DIV_W = osc_pkg::DIV_W_DEF
) (
    input  logic             fast_clk,
    input  logic             slow_clk,
    input  logic [DIV_W-1:0] div_cnt,
    input  logic [SEL_W-1:0] freq_sel,
    input  logic             src_fast,
    output logic             clk_out
);

    localparam int N_CODES = 2 ** SEL_W;

    logic [N_CODES-1:0] code_clk;
    logic               low_path;

    // Choose the source for the lowest frequency setting.
    always_comb begin
        low_path = src_fast ? div_cnt[DIV_W-1] : slow_clk;
    end

    // Build one candidate clock per code.
    for (genvar c = 0; c < N_CODES; c++) begin : g_code
        if (c == N_CODES - 1) begin : g_full
            assign code_clk[c] = fast_clk;
        end else if (c == 0) begin : g_low
            assign code_clk[c] = low_path;
        end else begin : g_tap
            assign code_clk[c] = div_cnt[osc_pkg::tap_bit(c)];
        end
    end

    // Route the candidate for the current code to the output.
    always_comb begin
        clk_out = code_clk[freq_sel];
    end

endmodule

// File: rtl/osc_postscaler.sv
// Module: top of the internal oscillator frequency postscaler.
// Assumes that fast_clk is the fast internal clock (about 16 MHz) and that
// slow_clk comes from the slow internal oscillator (about 31 kHz). The
// settings and the divider run on fast_clk with a synchronous active-low
// reset. The slow clock is always routed unchanged to lf_clk_out.
module osc_postscaler #(
    parameter int DIV_W = osc_pkg::DIV_W_DEF
) (
    input  logic                      fast_clk,
    input  logic                      slow_clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [osc_pkg::SEL_W-1:0] cfg_freq,
    input  logic                      cfg_src,
    output logic                      clk_out,
    output logic                      lf_clk_out
);

    localparam int SEL_W = osc_pkg::SEL_W;

    logic [DIV_W-1:0] div_cnt;
    logic [SEL_W-1:0] freq_q;
    logic             src_q;

    osc_div_chain #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk   (fast_clk),
        .rst_n (rst_n),
        .count (div_cnt)
    );

    osc_cfg_reg #(
        .SEL_W     (SEL_W),
        .RESET_SEL (osc_pkg::FSEL_RESET)
    ) u_cfg (
        .clk    (fast_clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .freq_d (cfg_freq),
        .src_d  (cfg_src),
        .freq_q (freq_q),
        .src_q  (src_q)
    );

    osc_tap_mux #(
        .SEL_W (SEL_W),
        .DIV_W (DIV_W)
    ) u_mux (
        .fast_clk (fast_clk),
        .slow_clk (slow_clk),
        .div_cnt  (div_cnt),
        .freq_sel (freq_q),
        .src_fast (src_q),
        .clk_out  (clk_out)
    );

    // Feed the watchdog and the clock monitor from the slow oscillator.
    always_comb begin
        lf_clk_out = slow_clk;
    end

endmodule

// File: rtl/osc_postscaler_chk.sv
// Module: assertion checker bound to osc_postscaler. It watches the
// settings register, the divider and the selected output on the fast clock.
module osc_postscaler_chk #(
    parameter int DIV_W = osc_pkg::DIV_W_DEF
) (
    input logic                      fast_clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [osc_pkg::SEL_W-1:0] cfg_freq,
    input logic                      cfg_src,
    input logic                      clk_out,
    input logic [osc_pkg::SEL_W-1:0] freq_q,
    input logic                      src_q,
    input logic [DIV_W-1:0]          div_cnt
);

    logic past_valid = 1'b0;

    // Mark that at least one fast-clock edge has been seen.
    always_ff @(posedge fast_clk) begin
        past_valid <= 1'b1;
    end

    // R1, R8: a reset cycle leaves the default code and a clear source bit.
    a_r1_reset_default: assert property (@(posedge fast_clk)
        (past_valid && !$past(rst_n)) |-> (freq_q == osc_pkg::FSEL_RESET && !src_q));

    // R7: a write is visible in the settings one edge later.
    a_r7_write_applies: assert property (@(posedge fast_clk) disable iff (!rst_n)
        cfg_we |=> (freq_q == $past(cfg_freq) && src_q == $past(cfg_src)));

    // R2: the fastest divided tap changes on every edge.
    a_r2_half_rate_toggles: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (past_valid && $past(rst_n) && freq_q == osc_pkg::FSEL_8M
         && $past(freq_q) == osc_pkg::FSEL_8M)
        |-> (clk_out != $past(clk_out)));

    // R3: the divide-by-512 path moves only when the low bits wrap.
    a_r3_div512_holds: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (past_valid && $past(rst_n) && freq_q == osc_pkg::FSEL_LOW && src_q
         && $past(freq_q) == osc_pkg::FSEL_LOW && $past(src_q)
         && $past(div_cnt[DIV_W-2:0]) != {(DIV_W-1){1'b1}})
        |-> $stable(clk_out));

endmodule

bind osc_postscaler osc_postscaler_chk #(.DIV_W(DIV_W)) u_chk (
    .fast_clk (fast_clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_freq (cfg_freq),
    .cfg_src  (cfg_src),
    .clk_out  (clk_out),
    .freq_q   (freq_q),
    .src_q    (src_q),
    .div_cnt  (div_cnt)
);

// File: tb/osc_postscaler_tb.sv
`timescale 1ns/1ps
// Bench: directed tests for osc_postscaler, one task per scenario.
module osc_postscaler_tb;

    localparam real FAST_T = 5.0;
    localparam real SLOW_T = 770.0;

    logic       fast_clk = 1'b0;
    logic       slow_clk = 1'b0;
    logic       rst_n    = 1'b0;
    logic       cfg_we   = 1'b0;
    logic [2:0] cfg_freq = 3'b000;
    logic       cfg_src  = 1'b0;
    logic       clk_out;
    logic       lf_clk_out;

    int n_cmp  = 0;
    int n_miss = 0;

    osc_postscaler u_dut (
        .fast_clk   (fast_clk),
        .slow_clk   (slow_clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_freq   (cfg_freq),
        .cfg_src    (cfg_src),
        .clk_out    (clk_out),
        .lf_clk_out (lf_clk_out)
    );

    always #2.5 fast_clk = ~fast_clk;
    always #385 slow_clk = ~slow_clk;

    task automatic check_real(input string req, input real act, input real exp);
        n_cmp++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            n_miss++;
            $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [2:0] f, input logic s);
        @(negedge fast_clk);
        cfg_we   = 1'b1;
        cfg_freq = f;
        cfg_src  = s;
        @(negedge fast_clk);
        cfg_we   = 1'b0;
    endtask

    // Skip two edges after a change, then time one full cycle.
    task automatic measure(output real per, output real hi);
        real t0;
        real t1;
        real t2;
        @(posedge clk_out);
        @(posedge clk_out);
        t0 = $realtime;
        @(negedge clk_out);
        t1 = $realtime;
        @(posedge clk_out);
        t2 = $realtime;
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    // R1: output is low in reset, and the default setting gives 1 MHz.
    task automatic t_reset;
        real per;
        real hi;
        rst_n = 1'b0;
        repeat (4) @(negedge fast_clk);
        check_bit("R1 clk_out low in reset", clk_out, 1'b0);
        rst_n = 1'b1;
        measure(per, hi);
        check_real("R1 default period", per, 16 * FAST_T);
    endtask

    // R2, R9: every divided and undivided code.
    task automatic t_codes;
        real per;
        real hi;
        for (int c = 7; c >= 1; c--) begin
            write_cfg(3'(c), 1'b0);
            measure(per, hi);
            check_real($sformatf("R2 period code %0d", c), per,
                       FAST_T * real'(1 << (7 - c)));
            check_real($sformatf("R9 high time code %0d", c), hi,
                       FAST_T * real'(1 << (7 - c)) / 2.0);
        end
    endtask

    // R3, R4, R9: both sources of the lowest setting.
    task automatic t_low_path;
        real per;
        real hi;
        write_cfg(3'b000, 1'b1);
        measure(per, hi);
        check_real("R3 fast/512 period", per, 512 * FAST_T);
        check_real("R9 fast/512 high time", hi, 256 * FAST_T);
        write_cfg(3'b000, 1'b0);
        measure(per, hi);
        check_real("R4 slow source period", per, SLOW_T);
        for (int i = 0; i < 8; i++) begin
            #97;
            check_bit("R4 clk_out follows slow_clk", clk_out, slow_clk);
        end
    endtask

    // R5: the source bit is ignored away from the lowest setting.
    task automatic t_src_ignored;
        real per;
        real hi;
        write_cfg(3'b101, 1'b1);
        measure(per, hi);
        check_real("R5 code 101 src=1", per, 4 * FAST_T);
        write_cfg(3'b010, 1'b1);
        measure(per, hi);
        check_real("R5 code 010 src=1", per, 32 * FAST_T);
    endtask

    // R6: the watchdog clock is the slow clock in every mode.
    task automatic t_watchdog;
        real t0;
        for (int m = 0; m < 3; m++) begin
            write_cfg(m == 0 ? 3'b000 : (m == 1 ? 3'b111 : 3'b011), m == 0);
            for (int i = 0; i < 6; i++) begin
                #131;
                check_bit("R6 lf_clk_out equals slow_clk", lf_clk_out, slow_clk);
            end
        end
        @(posedge lf_clk_out);
        t0 = $realtime;
        @(posedge lf_clk_out);
        check_real("R6 lf_clk_out period", $realtime - t0, SLOW_T);
    endtask

    // R7: a switch mid-count shows on the very next edge.
    task automatic t_switch;
        logic v [4];
        write_cfg(3'b000, 1'b1);
        repeat (100) @(negedge fast_clk);
        cfg_we   = 1'b1;
        cfg_freq = 3'b110;
        cfg_src  = 1'b0;
        @(negedge fast_clk);
        cfg_we   = 1'b0;
        v[0] = clk_out;
        for (int i = 1; i < 4; i++) begin
            @(negedge fast_clk);
            v[i] = clk_out;
        end
        for (int i = 1; i < 4; i++) begin
            check_bit("R7 new tap active at once", v[i], ~v[i-1]);
        end
    endtask

    // R8: reset beats a write in the same cycle.
    task automatic t_reset_vs_write;
        real per;
        real hi;
        @(negedge fast_clk);
        rst_n    = 1'b0;
        cfg_we   = 1'b1;
        cfg_freq = 3'b110;
        cfg_src  = 1'b1;
        @(negedge fast_clk);
        cfg_we   = 1'b0;
        rst_n    = 1'b1;
        measure(per, hi);
        check_real("R8 reset wins over write", per, 16 * FAST_T);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_codes();
                t_low_path();
                t_src_ignored();
                t_watchdog();
                t_switch();
                t_reset_vs_write();
            end
            begin
                #400000;
                n_cmp++;
                n_miss++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

endmodule